// File: doc/BRIEF.md
# Split-Transaction Bus Transaction Tracker

This block stands between the internal request sources (cache line fills, dirty line write-backs, uncached loads and stores) and an external system bus whose address and data phases are arbitrated and run separately. Each accepted request gets a 2-bit transaction tag. The block then wins the address bus through a request/grant pair and issues one address tenure. From then on it tracks the transaction until the data bus has moved all of its beats.

Two modes are selected by `mode_pipe`. In coupled mode only one transaction exists at a time, so a new address tenure waits until the previous data tenure has finished. In pipelined mode up to three transactions can be in flight. Read data tenures always follow the order of their address tenures. When `wr_bypass_en` is high, pending writes may run their data tenures ahead of an older read that is still waiting for its data. Every data byte lane carries a parity bit. The block generates parity on write beats and checks it on read beats; a read parity mismatch is flagged on that beat's response and also latched in a sticky error output.

Top module: `bus_txn_tracker`

## Requirements
- R1: Request kinds are encoded on `req_kind` as 2'b00 line fill, 2'b01 line write-back, 2'b10 uncached read and 2'b11 uncached write. The two line kinds move 4 data beats and the uncached kinds move 1 beat; bit 0 set means the data flows out to the bus.
- R2: `bus_br` stays high while an accepted request waits for its address tenure. `bus_ts` is high only in a cycle where `bus_bg` is high. In that cycle `bus_addr`, `bus_kind` and `bus_tag` carry the request's address, kind and tag. Address tenures follow acceptance order.
- R3: With `mode_pipe`=1 at most three transactions are in flight, counted from acceptance to the last data beat. While three are in flight, `req_ready` is low.
- R4: With `mode_pipe`=0, `req_ready` stays low from an acceptance until the last data beat of that transaction has completed.
- R5: When a request is accepted, `req_tag` gives the lowest-numbered tag that is not held by a transaction in flight. A tag is released on its last data beat.
- R6: Read data tenures start in the order of their address tenures.
- R7: With `wr_bypass_en`=0, all data tenures follow address order. With `wr_bypass_en`=1, when the oldest pending transaction is a read and a write is pending, the oldest pending write takes the next data tenure.
- R8: On each write beat, `bus_dout` carries `wr_data`. For every byte i, `bus_dpar_out[i]` makes that byte plus its parity bit hold an even number of ones (the PAR_ODD parameter inverts this).
- R9: A read beat whose `bus_dpar_in` differs from the even parity of `bus_din` in any byte raises `resp_perr` on that beat's response. It also sets `err_sticky`, which stays high until reset.
- R10: Every read beat with `bus_ta` high gives one `resp_valid` cycle carrying the tag, kind, beat index and `bus_din`. A write gives a single `resp_valid` on its last beat, with zero data and that beat's index.
- R11: During and right after reset, `req_ready`=1 and `bus_br`, `bus_dbr`, `resp_valid` and `err_sticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pipe | input | 1 | 1 = pipelined (up to 3 in flight), 0 = coupled |
| wr_bypass_en | input | 1 | Lets writes take data tenures ahead of an older read |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Request kind (see R1) |
| req_addr | input | 32 | Request address |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_tag | output | 2 | Tag assigned to the request accepted this cycle |
| bus_br | output | 1 | Address bus request |
| bus_bg | input | 1 | Address bus grant |
| bus_ts | output | 1 | Address tenure strobe |
| bus_addr | output | 32 | Address of the tenure |
| bus_kind | output | 2 | Kind of the tenure |
| bus_tag | output | 2 | Tag of the tenure |
| bus_dbr | output | 1 | Data bus request |
| bus_dbg | input | 1 | Data bus grant |
| bus_dact | output | 1 | Data tenure in progress |
| bus_dtag | output | 2 | Tag owning the current data tenure |
| dten_beat | output | 2 | Beat index within the current data tenure |
| bus_ta | input | 1 | Beat acknowledge from the bus |
| bus_dout | output | 64 | Write data to the bus |
| bus_dpar_out | output | 8 | Byte parity for bus_dout |
| bus_din | input | 64 | Read data from the bus |
| bus_dpar_in | input | 8 | Byte parity for bus_din |
| wr_data | input | 64 | Write beat data supplied for bus_dtag / dten_beat |
| resp_valid | output | 1 | Response beat valid |
| resp_tag | output | 2 | Response tag |
| resp_kind | output | 2 | Response kind |
| resp_beat | output | 2 | Response beat index |
| resp_data | output | 64 | Read data (zero for writes) |
| resp_perr | output | 1 | Parity error on this read beat |
| err_sticky | output | 1 | Latched read parity error |

## Verification
The assertions assume that `mode_pipe` changes only while nothing is in flight. They also assume that `bus_bg`, `bus_dbg` and `bus_ta` are raised only in answer to the block's own requests or an active tenure. The bench ties the grants to the matching request outputs and ties the acknowledge to `bus_dact`. It switches mode only after waiting for the tracker to drain. Ordering cases are built by holding the data grant low until every address tenure has been issued. This makes the data tenure order depend only on the rule under test.

// File: rtl/bt_pkg.sv
// Shared request-kind encoding and helpers for the bus transaction tracker.
package bt_pkg;
    typedef enum logic [1:0] {
        K_FILL  = 2'b00,
        K_WBACK = 2'b01,
        K_NCRD  = 2'b10,
        K_NCWR  = 2'b11
    } req_kind_e;

    // Data leaves the block on the bus for this kind.
    function automatic logic kind_is_write(req_kind_e k);
        return k[0];
    endfunction

    // Kind moves a whole line (multi-beat data tenure).
    function automatic logic kind_is_line(req_kind_e k);
        return !k[1];
    endfunction
endpackage

// File: rtl/bt_par_gen.sv
// Per-byte parity generator.
// Assumes DATA is a whole number of bytes; ODD=0 yields even parity per lane.
module bt_par_gen #(
    parameter int BYTES = 8,
    parameter bit ODD   = 1'b0
) (
    input  logic [8*BYTES-1:0] data,
    output logic [BYTES-1:0]   par
);
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        // One parity bit per byte lane.
        assign par[g] = (^data[8*g +: 8]) ^ ODD;
    end
endmodule

// File: rtl/bt_tag_pool.sv
// Tag allocator: hands out the lowest free tag and tracks which tags are held.
// Assumes the caller never allocates when every tag is held and frees only held tags.
module bt_tag_pool #(
    parameter int NT = 4,
    parameter int TW = 2,
    localparam int CW = $clog2(NT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic          free,
    input  logic [TW-1:0] free_tag,
    output logic [TW-1:0] alloc_tag,
    output logic [NT-1:0] busy,
    output logic [CW-1:0] n_busy
);
    // Pick the lowest-numbered free tag.
    always_comb begin
        alloc_tag = '0;
        for (int i = NT - 1; i >= 0; i--) begin
            if (!busy[i]) alloc_tag = TW'(i);
        end
    end

    // Count tags currently held.
    always_comb begin
        n_busy = '0;
        for (int i = 0; i < NT; i++) begin
            if (busy[i]) n_busy = n_busy + CW'(1);
        end
    end

    // Set on allocation, clear on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
        end else begin
            if (alloc) busy[alloc_tag] <= 1'b1;
            if (free)  busy[free_tag]  <= 1'b0;
        end
    end

    AST_FREE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        free |-> busy[free_tag]); // R5
    AST_ALLOC_UNHELD: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !busy[alloc_tag]); // R5
endmodule

// File: rtl/bt_order_q.sv
// Age-ordered list of transactions waiting for a data tenure.
// Entry 0 is the oldest. The list removes from any position and picks the next
// tenure: the oldest entry, or the oldest write when the oldest is a read and
// bypass is permitted. Assumes DEPTH >= 2 and no push into a full list without a pop.
module bt_order_q #(
    parameter int DEPTH = 3,
    parameter int TW    = 2,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [TW-1:0] push_tag,
    input  logic          push_wr,
    input  logic          pop,
    input  logic [IW-1:0] pop_idx,
    input  logic          permit,
    output logic [IW-1:0] sel_idx,
    output logic [TW-1:0] sel_tag,
    output logic          nonempty
);
    logic [TW-1:0]    q_tag [DEPTH];
    logic [DEPTH-1:0] q_wr;
    logic [CW-1:0]    cnt;
    logic [TW-1:0]    n_tag [DEPTH];
    logic [DEPTH-1:0] n_wr;
    logic [CW-1:0]    n_cnt;
    logic             has_w;
    logic [IW-1:0]    fw_idx;

    // Next list contents: close the gap left by a pop, then append a push.
    always_comb begin
        n_tag = q_tag;
        n_wr  = q_wr;
        n_cnt = cnt;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IW'(i) >= pop_idx) begin
                    n_tag[i] = q_tag[i+1];
                    n_wr[i]  = q_wr[i+1];
                end
            end
            n_cnt = cnt - CW'(1);
        end
        if (push && n_cnt < CW'(DEPTH)) begin
            n_tag[n_cnt[IW-1:0]] = push_tag;
            n_wr[n_cnt[IW-1:0]]  = push_wr;
            n_cnt = n_cnt + CW'(1);
        end
    end

    // Register the list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            q_wr <= '0;
            for (int i = 0; i < DEPTH; i++) q_tag[i] <= '0;
        end else begin
            cnt   <= n_cnt;
            q_wr  <= n_wr;
            q_tag <= n_tag;
        end
    end

    // Locate the oldest pending write.
    always_comb begin
        has_w  = 1'b0;
        fw_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (CW'(i) < cnt && q_wr[i]) begin
                has_w  = 1'b1;
                fw_idx = IW'(i);
            end
        end
    end

    // Choose the next data tenure.
    assign sel_idx  = (!q_wr[0] && permit && has_w) ? fw_idx : '0;
    assign sel_tag  = q_tag[sel_idx];
    assign nonempty = (cnt != '0);

    AST_Q_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (cnt < CW'(DEPTH))); // R3
    AST_Q_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0)); // R6
endmodule

// File: rtl/bus_txn_tracker.sv
// Split-transaction bus tracker.
// It accepts fill, write-back and uncached requests, wins the address bus and
// issues the address tenure, then runs data tenures matched by tag. Reads stay
// in address order; writes may go ahead of a read when bypass is enabled.
// Assumes mode_pipe changes only while idle and that grants and beat
// acknowledges come only in answer to the block's requests or an active tenure.
module bus_txn_tracker
    import bt_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int TAG_W       = 2,
    parameter int MAX_OUT     = 3,
    parameter int LINE_BEATS  = 4,
    parameter bit PAR_ODD     = 1'b0,
    localparam int BYTES = DATA_W / 8,
    localparam int BW    = $clog2(LINE_BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pipe,
    input  logic              wr_bypass_en,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [TAG_W-1:0]  req_tag,
    output logic              bus_br,
    input  logic              bus_bg,
    output logic              bus_ts,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_kind,
    output logic [TAG_W-1:0]  bus_tag,
    output logic              bus_dbr,
    input  logic              bus_dbg,
    output logic              bus_dact,
    output logic [TAG_W-1:0]  bus_dtag,
    output logic [BW-1:0]     dten_beat,
    input  logic              bus_ta,
    output logic [DATA_W-1:0] bus_dout,
    output logic [BYTES-1:0]  bus_dpar_out,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [BYTES-1:0]  bus_dpar_in,
    input  logic [DATA_W-1:0] wr_data,
    output logic              resp_valid,
    output logic [TAG_W-1:0]  resp_tag,
    output logic [1:0]        resp_kind,
    output logic [BW-1:0]     resp_beat,
    output logic [DATA_W-1:0] resp_data,
    output logic              resp_perr,
    output logic              err_sticky
);
    localparam int NTAGS = 1 << TAG_W;
    localparam int CW    = $clog2(NTAGS + 1);
    localparam int IW    = $clog2(MAX_OUT);

    // Address-side holding register
    logic              h_valid;
    logic [1:0]        h_kind;
    logic [ADDR_W-1:0] h_addr;
    logic [TAG_W-1:0]  h_tag;
    logic [1:0]        kind_tab [NTAGS];

    // Tag pool and order list
    logic [TAG_W-1:0]  alloc_tag;
    logic [NTAGS-1:0]  busy;
    logic [CW-1:0]     n_busy;
    logic [CW-1:0]     limit;
    logic              req_fire;
    logic [IW-1:0]     sel_idx;
    logic [TAG_W-1:0]  sel_tag;
    logic              q_nonempty;

    // Data tenure state
    logic              d_active;
    logic [TAG_W-1:0]  d_tag;
    logic [1:0]        d_kind;
    logic [BW-1:0]     d_beat;
    logic              d_wr, d_last, d_start, beat_fire, d_done;
    logic [BYTES-1:0]  rx_par;
    logic              err_q;

    // Request acceptance, bounded by the mode's in-flight limit.
    assign limit     = mode_pipe ? CW'(MAX_OUT) : CW'(1);
    assign req_ready = !h_valid && (n_busy < limit);
    assign req_fire  = req_valid && req_ready;
    assign req_tag   = alloc_tag;

    // Address tenure presented from the holding register.
    assign bus_br   = h_valid;
    assign bus_ts   = h_valid && bus_bg;
    assign bus_addr = h_addr;
    assign bus_kind = h_kind;
    assign bus_tag  = h_tag;

    // Load on acceptance, empty once the address tenure goes out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_valid <= 1'b0;
            h_kind  <= '0;
            h_addr  <= '0;
            h_tag   <= '0;
        end else if (req_fire) begin
            h_valid <= 1'b1;
            h_kind  <= req_kind;
            h_addr  <= req_addr;
            h_tag   <= alloc_tag;
        end else if (bus_ts) begin
            h_valid <= 1'b0;
        end
    end

    // Remember each tag's kind for its data tenure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTAGS; i++) kind_tab[i] <= '0;
        end else if (req_fire) begin
            kind_tab[alloc_tag] <= req_kind;
        end
    end

    bt_tag_pool #(.NT(NTAGS), .TW(TAG_W)) u_pool (
        .clk(clk), .rst_n(rst_n),
        .alloc(req_fire), .free(d_done), .free_tag(d_tag),
        .alloc_tag(alloc_tag), .busy(busy), .n_busy(n_busy)
    );

    bt_order_q #(.DEPTH(MAX_OUT), .TW(TAG_W)) u_order (
        .clk(clk), .rst_n(rst_n),
        .push(bus_ts), .push_tag(h_tag), .push_wr(kind_is_write(req_kind_e'(h_kind))),
        .pop(d_start), .pop_idx(sel_idx), .permit(wr_bypass_en),
        .sel_idx(sel_idx), .sel_tag(sel_tag), .nonempty(q_nonempty)
    );

    // Data tenure sequencing.
    assign bus_dbr   = !d_active && q_nonempty;
    assign d_start   = bus_dbr && bus_dbg;
    assign d_wr      = kind_is_write(req_kind_e'(d_kind));
    assign d_last    = kind_is_line(req_kind_e'(d_kind)) ? (d_beat == BW'(LINE_BEATS - 1)) : 1'b1;
    assign beat_fire = d_active && bus_ta;
    assign d_done    = beat_fire && d_last;

    // Start, advance and finish the active data tenure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_active <= 1'b0;
            d_tag    <= '0;
            d_kind   <= '0;
            d_beat   <= '0;
        end else if (d_start) begin
            d_active <= 1'b1;
            d_tag    <= sel_tag;
            d_kind   <= kind_tab[sel_tag];
            d_beat   <= '0;
        end else if (d_done) begin
            d_active <= 1'b0;
        end else if (beat_fire) begin
            d_beat <= d_beat + BW'(1);
        end
    end

    assign bus_dact  = d_active;
    assign bus_dtag  = d_tag;
    assign dten_beat = d_beat;
    assign bus_dout  = (d_active && d_wr) ? wr_data : '0;

    bt_par_gen #(.BYTES(BYTES), .ODD(PAR_ODD)) u_txpar (.data(bus_dout), .par(bus_dpar_out));
    bt_par_gen #(.BYTES(BYTES), .ODD(PAR_ODD)) u_rxpar (.data(bus_din),  .par(rx_par));

    // Response beats back to the requester.
    assign resp_valid = beat_fire && (!d_wr || d_last);
    assign resp_tag   = d_tag;
    assign resp_kind  = d_kind;
    assign resp_beat  = d_beat;
    assign resp_data  = d_wr ? '0 : bus_din;
    assign resp_perr  = !d_wr && (rx_par != bus_dpar_in);

    // Latch any read parity error until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                       err_q <= 1'b0;
        else if (resp_valid && resp_perr) err_q <= 1'b1;
    end
    assign err_sticky = err_q;

    AST_OUT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        n_busy <= CW'(MAX_OUT)); // R3
    AST_COUPLED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_pipe |-> (n_busy <= CW'(1))); // R4
    AST_BYPASS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (d_start && sel_idx != '0) |-> wr_bypass_en); // R7
    AST_DTAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        d_active |-> busy[d_tag]); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R9
endmodule

// File: tb/bus_txn_tracker_tb.sv
module bus_txn_tracker_tb;
    import bt_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, mode_pipe, wr_bypass_en, req_valid;
    logic [1:0]  req_kind;
    logic [31:0] req_addr;
    logic        req_ready;
    logic [1:0]  req_tag;
    logic        bus_br, bus_bg, bus_ts;
    logic [31:0] bus_addr;
    logic [1:0]  bus_kind, bus_tag;
    logic        bus_dbr, bus_dbg, bus_dact;
    logic [1:0]  bus_dtag, dten_beat;
    logic        bus_ta;
    logic [63:0] bus_dout, bus_din, wr_data, resp_data;
    logic [7:0]  bus_dpar_out, bus_dpar_in;
    logic        resp_valid, resp_perr, err_sticky;
    logic [1:0]  resp_tag, resp_kind, resp_beat;

    logic bg_en = 1'b0, dbg_en = 1'b0, ta_en = 1'b1, bad_par = 1'b0;
    int   errors = 0, checks = 0, open_cnt = 0;
    bit   finished = 1'b0;
    logic [1:0] bkind [4];

    function automatic logic [63:0] rd_word(logic [1:0] t, logic [1:0] b);
        return {16'hD00D, 6'd0, t, 6'd0, b, 32'h0F1E_2D3C};
    endfunction
    function automatic logic [63:0] wr_word(logic [1:0] t, logic [1:0] b);
        return {16'hBEEF, 6'd0, t, 6'd0, b, 32'hC3C3_5A5A};
    endfunction
    function automatic logic [7:0] par8(logic [63:0] d);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) p[i] = ^d[8*i +: 8];
        return p;
    endfunction

    // Bus and data-source models
    assign bus_bg      = bus_br & bg_en;
    assign bus_dbg     = bus_dbr & dbg_en;
    assign bus_ta      = bus_dact & ta_en;
    assign bus_din     = bus_dact ? rd_word(bus_dtag, dten_beat) : 64'd0;
    assign bus_dpar_in = par8(bus_din) ^ {7'd0, bad_par};
    assign wr_data     = wr_word(bus_dtag, dten_beat);

    bus_txn_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .wr_bypass_en(wr_bypass_en),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_ready(req_ready), .req_tag(req_tag),
        .bus_br(bus_br), .bus_bg(bus_bg), .bus_ts(bus_ts), .bus_addr(bus_addr),
        .bus_kind(bus_kind), .bus_tag(bus_tag),
        .bus_dbr(bus_dbr), .bus_dbg(bus_dbg), .bus_dact(bus_dact), .bus_dtag(bus_dtag),
        .dten_beat(dten_beat), .bus_ta(bus_ta), .bus_dout(bus_dout), .bus_dpar_out(bus_dpar_out),
        .bus_din(bus_din), .bus_dpar_in(bus_dpar_in), .wr_data(wr_data),
        .resp_valid(resp_valid), .resp_tag(resp_tag), .resp_kind(resp_kind),
        .resp_beat(resp_beat), .resp_data(resp_data), .resp_perr(resp_perr),
        .err_sticky(err_sticky)
    );

    typedef struct {
        logic [1:0]  tag;
        logic [1:0]  kind;
        logic [1:0]  beat;
        logic [63:0] data;
        logic        perr;
        string       rq;
    } exp_t;
    typedef struct {
        logic [31:0] addr;
        logic [1:0]  kind;
        logic [1:0]  tag;
    } aexp_t;
    exp_t  sb [$];
    aexp_t aq [$];

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Push the expected response beats of one transaction
    task automatic expect_txn(input logic [1:0] t, input logic [1:0] k, input logic bp, input string rq);
        exp_t e;
        if (k[0]) begin
            e.tag = t; e.kind = k; e.beat = k[1] ? 2'd0 : 2'd3; e.data = 64'd0; e.perr = 1'b0; e.rq = rq;
            sb.push_back(e);
        end else begin
            for (int b = 0; b < (k[1] ? 1 : 4); b++) begin
                e.tag = t; e.kind = k; e.beat = 2'(b); e.data = rd_word(t, 2'(b)); e.perr = bp; e.rq = rq;
                sb.push_back(e);
            end
        end
    endtask

    // Driver: offer a request until accepted, checking the tag it gets
    task automatic send(input logic [1:0] k, input logic [31:0] a, input logic [1:0] exp_tag);
        aexp_t ae;
        ae.addr = a; ae.kind = k; ae.tag = exp_tag;
        aq.push_back(ae);
        @(posedge clk); #1;
        req_valid = 1'b1; req_kind = k; req_addr = a;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        chk("R5", "req_tag", 64'(req_tag), 64'(exp_tag));
        bkind[exp_tag] = k;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (sb.size() == 0 && aq.size() == 0 && open_cnt == 0 && !bus_dact) break;
        end
        repeat (2) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (req_valid && req_ready) begin
                if (mode_pipe) chk("R3", "in flight at accept", 64'(open_cnt < 3), 64'd1);
                else           chk("R4", "in flight at accept", 64'(open_cnt), 64'd0);
                open_cnt++;
            end
            if (bus_ts) begin
                chk("R2", "grant at tenure", 64'(bus_bg), 64'd1);
                if (aq.size() == 0) chk("R2", "unexpected address tenure", 64'd1, 64'd0);
                else begin
                    aexp_t ae;
                    ae = aq.pop_front();
                    chk("R2", "bus_addr", 64'(bus_addr), 64'(ae.addr));
                    chk("R2", "bus_kind", 64'(bus_kind), 64'(ae.kind));
                    chk("R2", "bus_tag",  64'(bus_tag),  64'(ae.tag));
                end
            end
            if (bus_dact && bus_ta && bkind[bus_dtag][0]) begin
                chk("R8", "bus_dout", bus_dout, wr_word(bus_dtag, dten_beat));
                chk("R8", "bus_dpar_out", 64'(bus_dpar_out), 64'(par8(wr_word(bus_dtag, dten_beat))));
            end
            if (resp_valid) begin
                if (sb.size() == 0) chk("R10", "unexpected response", 64'd1, 64'd0);
                else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(e.rq, "resp_tag",  64'(resp_tag),  64'(e.tag));
                    chk(e.rq, "resp_kind", 64'(resp_kind), 64'(e.kind));
                    chk(e.rq, "resp_beat", 64'(resp_beat), 64'(e.beat));
                    chk(e.rq, "resp_data", resp_data, e.data);
                    chk(e.rq, "resp_perr", 64'(resp_perr), 64'(e.perr));
                end
                if (resp_kind[0] || resp_kind[1] || resp_beat == 2'd3) open_cnt--;
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        rst_n = 1'b0; mode_pipe = 1'b1; wr_bypass_en = 1'b0;
        req_valid = 1'b0; req_kind = 2'b00; req_addr = 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", "req_ready", 64'(req_ready), 64'd1);
        chk("R11", "bus_br", 64'(bus_br), 64'd0);
        chk("R11", "bus_dbr", 64'(bus_dbr), 64'd0);
        chk("R11", "resp_valid", 64'(resp_valid), 64'd0);
        chk("R11", "err_sticky", 64'(err_sticky), 64'd0);
        @(posedge clk); #1;
        rst_n = 1'b1; bg_en = 1'b1; dbg_en = 1'b1;

        // R1 / R10: single uncached read, line fill, line write-back
        send(K_NCRD, 32'h1000_0040, 2'd0); expect_txn(2'd0, K_NCRD, 1'b0, "R10"); wait_idle();
        send(K_FILL, 32'h2000_0100, 2'd0); expect_txn(2'd0, K_FILL, 1'b0, "R1");  wait_idle();
        send(K_WBACK, 32'h3000_0200, 2'd0); expect_txn(2'd0, K_WBACK, 1'b0, "R1"); wait_idle();

        // R2: request held without grant
        bg_en = 1'b0;
        send(K_NCWR, 32'h4000_0008, 2'd0);
        repeat (3) @(negedge clk);
        chk("R2", "bus_br while waiting", 64'(bus_br), 64'd1);
        chk("R2", "bus_ts without grant", 64'(bus_ts), 64'd0);
        expect_txn(2'd0, K_NCWR, 1'b0, "R10");
        @(posedge clk); #1; bg_en = 1'b1;
        wait_idle();

        // R3: three in flight, fourth waits
        dbg_en = 1'b0;
        send(K_NCRD, 32'h5000_0000, 2'd0);
        send(K_NCRD, 32'h5000_0008, 2'd1);
        send(K_NCRD, 32'h5000_0010, 2'd2);
        repeat (4) @(negedge clk);
        chk("R3", "req_ready at limit", 64'(req_ready), 64'd0);
        expect_txn(2'd0, K_NCRD, 1'b0, "R6");
        expect_txn(2'd1, K_NCRD, 1'b0, "R6");
        expect_txn(2'd2, K_NCRD, 1'b0, "R6");
        @(posedge clk); #1; dbg_en = 1'b1;
        send(K_NCRD, 32'h5000_0018, 2'd0); expect_txn(2'd0, K_NCRD, 1'b0, "R5");
        wait_idle();

        // R7: bypass disabled keeps address order
        dbg_en = 1'b0; wr_bypass_en = 1'b0;
        send(K_NCRD, 32'h6000_0000, 2'd0);
        send(K_NCWR, 32'h6000_0008, 2'd1);
        send(K_FILL, 32'h6000_0040, 2'd2);
        repeat (4) @(negedge clk);
        expect_txn(2'd0, K_NCRD, 1'b0, "R7");
        expect_txn(2'd1, K_NCWR, 1'b0, "R7");
        expect_txn(2'd2, K_FILL, 1'b0, "R6");
        @(posedge clk); #1; dbg_en = 1'b1;
        wait_idle();

        // R7: bypass enabled, one write passes the read
        dbg_en = 1'b0; wr_bypass_en = 1'b1;
        send(K_NCRD, 32'h7000_0000, 2'd0);
        send(K_NCWR, 32'h7000_0008, 2'd1);
        send(K_NCRD, 32'h7000_0010, 2'd2);
        repeat (4) @(negedge clk);
        expect_txn(2'd1, K_NCWR, 1'b0, "R7");
        expect_txn(2'd0, K_NCRD, 1'b0, "R7");
        expect_txn(2'd2, K_NCRD, 1'b0, "R6");
        @(posedge clk); #1; dbg_en = 1'b1;
        wait_idle();

        // R7: bypass enabled, two writes pass the read
        dbg_en = 1'b0;
        send(K_NCRD,  32'h7100_0000, 2'd0);
        send(K_WBACK, 32'h7100_0040, 2'd1);
        send(K_NCWR,  32'h7100_0080, 2'd2);
        repeat (4) @(negedge clk);
        expect_txn(2'd1, K_WBACK, 1'b0, "R7");
        expect_txn(2'd2, K_NCWR, 1'b0, "R7");
        expect_txn(2'd0, K_NCRD, 1'b0, "R7");
        @(posedge clk); #1; dbg_en = 1'b1;
        wait_idle();
        wr_bypass_en = 1'b0;

        // R4: coupled mode
        mode_pipe = 1'b0;
        send(K_NCRD, 32'h8000_0000, 2'd0);
        chk("R4", "req_ready while in flight", 64'(req_ready), 64'd0);
        expect_txn(2'd0, K_NCRD, 1'b0, "R4");
        send(K_FILL, 32'h8000_0040, 2'd0); expect_txn(2'd0, K_FILL, 1'b0, "R4");
        wait_idle();
        mode_pipe = 1'b1;

        // R9: read parity error and stickiness
        chk("R9", "err_sticky before error", 64'(err_sticky), 64'd0);
        bad_par = 1'b1;
        send(K_NCRD, 32'h9000_0000, 2'd0); expect_txn(2'd0, K_NCRD, 1'b1, "R9");
        wait_idle();
        bad_par = 1'b0;
        chk("R9", "err_sticky after error", 64'(err_sticky), 64'd1);
        send(K_NCRD, 32'h9000_0008, 2'd0); expect_txn(2'd0, K_NCRD, 1'b0, "R9");
        wait_idle();
        chk("R9", "err_sticky stays set", 64'(err_sticky), 64'd1);

        chk("R10", "leftover expected responses", 64'(sb.size()), 64'd0);
        chk("R2", "leftover expected address tenures", 64'(aq.size()), 64'd0);
        summary();
    end
endmodule